// File: doc/BRIEF.md
# Load-Store Effective Address and Lane Formatter

This unit sits between a register-read stage and a simple 64-bit synchronous data memory. For each request it forms the effective address from a base value and a signed immediate, drives the memory port with a doubleword-aligned address, byte enables and lane-positioned write data, and one cycle later returns the loaded value and the updated base. The base can come from a general register or from the program counter. The offset can be added before the access, after the access, or used without changing the base.

Four access widths are handled: 8, 16, 32 and 64 bits. A 64-bit access moves a pair of 32-bit registers. Narrow loads come back zero-extended. Any access whose address is not a multiple of its own size is refused. It raises a fault flag in the response cycle and has no side effect on memory or on the base register.

Top module: `lsu_agu_top`

## Requirements
- R1: With `req_mode` 0 (plain) or 3 (treated as plain), the access address is base plus offset and `wb_en` stays low in the response cycle.
- R2: With `req_mode` 1 (pre-update), the access address is base plus offset, and that same sum appears on `wb_value` with `wb_en` high in the response cycle.
- R3: With `req_mode` 2 (post-update), the access uses the unmodified base, and base plus offset appears on `wb_value` with `wb_en` high in the response cycle.
- R4: `req_offset` is a 13-bit two's-complement value sign-extended to 32 bits. Negative values subtract from the base and zero leaves it unchanged.
- R5: With `req_pc_rel` high, `req_pc` replaces `req_base` as the base, and no writeback is signalled in any mode.
- R6: `req_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. `mem_be` sets 1, 2, 4 or 8 consecutive bits starting at bit `addr[2:0]`, with little-endian lanes (byte lane k is `mem_wdata[8k+7:8k]`).
- R7: On a store, byte lane k of `mem_wdata` carries source byte (k mod access-bytes) of {`req_wdata_hi`,`req_wdata_lo`}, so the data is repeated into every lane and the enabled lanes hold it in place.
- R8: A byte, halfword or word load returns the addressed lanes of `mem_rdata` on `rsp_load_lo`, zero-extended to 32 bits, with `rsp_load_hi` zero.
- R9: A doubleword store takes the lower-address word from `req_wdata_lo` and the upper from `req_wdata_hi`. A doubleword load returns the lower-address word on `rsp_load_lo` and the upper on `rsp_load_hi`.
- R10: A halfword, word or doubleword access whose address is not a multiple of its size keeps `mem_req` low. In the next cycle it raises `align_fault`, with `rsp_valid` and `wb_en` low.
- R11: The memory port is driven in the request cycle, and `mem_addr` has its low three bits zero. `rsp_valid`, the load data and `wb_en` are valid together exactly one cycle later.
- R12: After reset, `rsp_valid`, `wb_en`, `align_fault` and both load outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 plain, 1 pre-update, 2 post-update, 3 plain |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_pc_rel | input | 1 | Use the program counter as base |
| req_base | input | 32 | Base register value |
| req_pc | input | 32 | Program counter value |
| req_offset | input | 13 | Signed immediate offset |
| req_wdata_lo | input | 32 | Store data, first register |
| req_wdata_hi | input | 32 | Store data, second register (doubleword) |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Doubleword-aligned memory address |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-positioned write data |
| mem_rdata | input | 64 | Read data, one cycle after `mem_req` |
| rsp_valid | output | 1 | Response cycle of an accepted access |
| rsp_load_lo | output | 32 | Loaded value / lower doubleword word |
| rsp_load_hi | output | 32 | Upper doubleword word |
| wb_en | output | 1 | Base register writeback strobe |
| wb_value | output | 32 | Updated base value |
| align_fault | output | 1 | Misaligned request refused |

## Verification
The assertions assume that `req_*` inputs are stable for the whole request cycle. They also assume that `mem_rdata` is a registered read of the cycle-earlier address, so that the response-cycle checks see a quiet port. The scoreboard drives each request at a falling edge and holds it until the next one. Its memory model answers with exactly one cycle of latency, and every address it uses falls inside a 128-byte window, so shadow and model never disagree. Misaligned cases are chosen for each width and each mode, including a store, so that the suppression of both memory and writeback is exercised.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        IDX_PLAIN = 2'd0,
        IDX_PRE   = 2'd1,
        IDX_POST  = 2'd2,
        IDX_ALT   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 13
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            pc_rel_i,
    input  logic [OFFW-1:0] offset_i,
    input  idx_mode_e       mode_i,
    output logic [XLEN-1:0] eff_addr_o,
    output logic [XLEN-1:0] upd_base_o,
    output logic            upd_req_o
);

    logic [XLEN-1:0] sel_base;
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] sum;

    always_comb begin
        sel_base   = pc_rel_i ? pc_i : base_i;
        off_ext    = {{(XLEN-OFFW){offset_i[OFFW-1]}}, offset_i};
        sum        = sel_base + off_ext;
        eff_addr_o = (mode_i == IDX_POST) ? sel_base : sum;
        upd_base_o = sum;
        upd_req_o  = !pc_rel_i && ((mode_i == IDX_PRE) || (mode_i == IDX_POST));
    end

endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_size_e                     size_i,
    input  logic [$clog2(XLEN/4)-1:0]     lane_i,
    input  logic [XLEN-1:0]               wlo_i,
    input  logic [XLEN-1:0]               whi_i,
    output logic [XLEN/4-1:0]             be_o,
    output logic [2*XLEN-1:0]             wdata_o,
    output logic                          misaligned_o
);

    localparam int BUS_BYTES = XLEN / 4;
    localparam int LANEW     = $clog2(BUS_BYTES);
    localparam int REG_BYTES = XLEN / 8;

    logic [LANEW-1:0]     size_m1;
    logic [BUS_BYTES-1:0] lane_mask;
    logic [2*XLEN-1:0]    src;

    always_comb begin
        src = {whi_i, wlo_i};
        unique case (size_i)
            SZ_BYTE: begin
                size_m1   = '0;
                lane_mask = BUS_BYTES'(1);
            end
            SZ_HALF: begin
                size_m1   = LANEW'(1);
                lane_mask = BUS_BYTES'(3);
            end
            SZ_WORD: begin
                size_m1   = LANEW'(REG_BYTES - 1);
                lane_mask = BUS_BYTES'({REG_BYTES{1'b1}});
            end
            default: begin
                size_m1   = LANEW'(BUS_BYTES - 1);
                lane_mask = {BUS_BYTES{1'b1}};
            end
        endcase
        misaligned_o = |(lane_i & size_m1);
        be_o         = lane_mask << lane_i;
    end

    for (genvar gi = 0; gi < BUS_BYTES; gi++) begin : g_lane
        logic [LANEW-1:0] src_sel;
        always_comb begin
            src_sel                = LANEW'(gi) & size_m1;
            wdata_o[8*gi +: 8]     = src[{src_sel, 3'b000} +: 8];
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_size_e                     size_i,
    input  logic [$clog2(XLEN/4)-1:0]     lane_i,
    input  logic [2*XLEN-1:0]             rdata_i,
    output logic [XLEN-1:0]               lo_o,
    output logic [XLEN-1:0]               hi_o
);

    logic [2*XLEN-1:0] shifted;

    always_comb begin
        shifted = rdata_i >> {lane_i, 3'b000};
        hi_o    = '0;
        unique case (size_i)
            SZ_BYTE:  lo_o = {{(XLEN-8){1'b0}},  shifted[7:0]};
            SZ_HALF:  lo_o = {{(XLEN-16){1'b0}}, shifted[15:0]};
            SZ_WORD:  lo_o = shifted[XLEN-1:0];
            default: begin
                lo_o = rdata_i[XLEN-1:0];
                hi_o = rdata_i[2*XLEN-1:XLEN];
            end
        endcase
    end

endmodule

// File: rtl/lsu_agu_top.sv
module lsu_agu_top
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_store,
    input  logic [1:0]           req_mode,
    input  logic [1:0]           req_size,
    input  logic                 req_pc_rel,
    input  logic [XLEN-1:0]      req_base,
    input  logic [XLEN-1:0]      req_pc,
    input  logic [OFFW-1:0]      req_offset,
    input  logic [XLEN-1:0]      req_wdata_lo,
    input  logic [XLEN-1:0]      req_wdata_hi,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [XLEN-1:0]      mem_addr,
    output logic [XLEN/4-1:0]    mem_be,
    output logic [2*XLEN-1:0]    mem_wdata,
    input  logic [2*XLEN-1:0]    mem_rdata,
    output logic                 rsp_valid,
    output logic [XLEN-1:0]      rsp_load_lo,
    output logic [XLEN-1:0]      rsp_load_hi,
    output logic                 wb_en,
    output logic [XLEN-1:0]      wb_value,
    output logic                 align_fault
);

    localparam int BUS_BYTES = XLEN / 4;
    localparam int LANEW     = $clog2(BUS_BYTES);

    typedef struct packed {
        logic             valid;
        logic             store;
        acc_size_e        size;
        logic [LANEW-1:0] lane;
        logic             wb;
        logic [XLEN-1:0]  wb_val;
        logic             fault;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    idx_mode_e            mode;
    acc_size_e            size;
    logic [XLEN-1:0]      eff_addr;
    logic [XLEN-1:0]      upd_base;
    logic                 upd_req;
    logic [BUS_BYTES-1:0] fmt_be;
    logic [2*XLEN-1:0]    fmt_wdata;
    logic                 misaligned;
    logic                 accept;
    logic [XLEN-1:0]      ext_lo;
    logic [XLEN-1:0]      ext_hi;

    assign mode = idx_mode_e'(req_mode);
    assign size = acc_size_e'(req_size);

    lsu_addr_gen #(.XLEN(XLEN), .OFFW(OFFW)) u_addr_gen (
        .base_i     (req_base),
        .pc_i       (req_pc),
        .pc_rel_i   (req_pc_rel),
        .offset_i   (req_offset),
        .mode_i     (mode),
        .eff_addr_o (eff_addr),
        .upd_base_o (upd_base),
        .upd_req_o  (upd_req)
    );

    lsu_store_fmt #(.XLEN(XLEN)) u_store_fmt (
        .size_i       (size),
        .lane_i       (eff_addr[LANEW-1:0]),
        .wlo_i        (req_wdata_lo),
        .whi_i        (req_wdata_hi),
        .be_o         (fmt_be),
        .wdata_o      (fmt_wdata),
        .misaligned_o (misaligned)
    );

    lsu_load_extract #(.XLEN(XLEN)) u_load_extract (
        .size_i  (st_q.size),
        .lane_i  (st_q.lane),
        .rdata_i (mem_rdata),
        .lo_o    (ext_lo),
        .hi_o    (ext_hi)
    );

    // Next-state and request-side outputs
    always_comb begin
        accept       = req_valid && !misaligned;
        st_d         = '0;
        st_d.valid   = accept;
        st_d.store   = accept && req_store;
        st_d.size    = accept ? size : SZ_BYTE;
        st_d.lane    = accept ? eff_addr[LANEW-1:0] : '0;
        st_d.wb      = accept && upd_req;
        st_d.wb_val  = (accept && upd_req) ? upd_base : '0;
        st_d.fault   = req_valid && misaligned;

        mem_req   = accept;
        mem_we    = accept && req_store;
        mem_addr  = accept ? {eff_addr[XLEN-1:LANEW], {LANEW{1'b0}}} : '0;
        mem_be    = accept ? fmt_be : '0;
        mem_wdata = (accept && req_store) ? fmt_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rsp_valid   = st_q.valid;
        rsp_load_lo = (st_q.valid && !st_q.store) ? ext_lo : '0;
        rsp_load_hi = (st_q.valid && !st_q.store) ? ext_hi : '0;
        wb_en       = st_q.wb;
        wb_value    = st_q.wb_val;
        align_fault = st_q.fault;
    end

    // Plain (and alternate plain) mode never updates the base
    assert_plain_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (req_mode == 2'd0 || req_mode == 2'd3)) |=> !wb_en);

    // Pre/post update with a register base always writes back
    assert_update_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_pc_rel && (req_mode == 2'd1 || req_mode == 2'd2)) |=> wb_en);

    // Program-counter base is never written back
    assert_pc_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_pc_rel) |=> !wb_en);

    // Lane count follows the size code
    assert_be_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == (1 << req_size)));

    // A refused request shows up as a fault in the next cycle, with nothing else
    assert_refused_faults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req) |=> (align_fault && !rsp_valid && !wb_en));

    // Responses only follow an issued memory access
    assert_rsp_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_req));

    // Writeback is only ever signalled together with a response
    assert_wb_with_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> rsp_valid);

endmodule

// File: tb/lsu_agu_top_bench.sv
module lsu_agu_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic        req_pc_rel = 1'b0;
    logic [31:0] req_base = '0;
    logic [31:0] req_pc = '0;
    logic [12:0] req_offset = '0;
    logic [31:0] req_wdata_lo = '0;
    logic [31:0] req_wdata_hi = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid, wb_en, align_fault;
    logic [31:0] rsp_load_lo, rsp_load_hi, wb_value;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_agu_top u_lsu_agu_top (
        .clk, .rst_n, .req_valid, .req_store, .req_mode, .req_size, .req_pc_rel,
        .req_base, .req_pc, .req_offset, .req_wdata_lo, .req_wdata_hi,
        .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
        .rsp_valid, .rsp_load_lo, .rsp_load_hi, .wb_en, .wb_value, .align_fault
    );

    // Memory model driven by the design, and a shadow maintained by the driver
    logic [63:0] ram    [16];
    logic [63:0] shadow [16];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) ram[mem_addr[6:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= ram[mem_addr[6:3]];
            end
        end
    end

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        int          cyc;
        logic        valid;
        logic        wb;
        logic [31:0] wbv;
        logic [31:0] lo;
        logic [31:0] hi;
        logic        fault;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // Monitor: compares the response one cycle after each pushed item
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].cyc == cyc - 1) begin
            exp_t e;
            e = sb_q.pop_front();
            check(rsp_valid == e.valid, {e.tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'(e.valid));
            check(wb_en == e.wb, {e.tag, " wb_en"}, 64'(wb_en), 64'(e.wb));
            check(wb_value == e.wbv, {e.tag, " wb_value"}, 64'(wb_value), 64'(e.wbv));
            check(align_fault == e.fault, {e.tag, " R10 align_fault"}, 64'(align_fault), 64'(e.fault));
            check(rsp_load_lo == e.lo, {e.tag, " load_lo"}, 64'(rsp_load_lo), 64'(e.lo));
            check(rsp_load_hi == e.hi, {e.tag, " load_hi"}, 64'(rsp_load_hi), 64'(e.hi));
        end
    end

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic issue(input bit st, input logic [1:0] mode, input logic [1:0] size,
                         input bit pcr, input logic [31:0] base, input logic [31:0] pc,
                         input logic [12:0] off, input logic [31:0] wlo,
                         input logic [31:0] whi, input string tag);
        logic [31:0] sb, sum, ea;
        logic [63:0] src, wexp, word, sh;
        logic [7:0]  be_exp;
        int          n, lane;
        bit          mis;
        exp_t        e;
        req_valid = 1'b1; req_store = st; req_mode = mode; req_size = size;
        req_pc_rel = pcr; req_base = base; req_pc = pc; req_offset = off;
        req_wdata_lo = wlo; req_wdata_hi = whi;
        sb   = pcr ? pc : base;
        sum  = sb + {{19{off[12]}}, off};
        ea   = (mode == 2'd2) ? sb : sum;
        n    = 1 << size;
        lane = int'(ea[2:0]);
        mis  = (int'(ea[2:0]) % n) != 0;
        be_exp = 8'(((1 << n) - 1) << lane);
        src  = {whi, wlo};
        for (int b = 0; b < 8; b++) wexp[8*b +: 8] = src[8*(b % n) +: 8];
        #1;
        check(mem_req == !mis, {tag, " R10 mem_req"}, 64'(mem_req), 64'(!mis));
        if (!mis) begin
            check(mem_addr == {ea[31:3], 3'b000}, {tag, " R11 mem_addr"}, 64'(mem_addr), 64'({ea[31:3], 3'b000}));
            check(mem_we == st, {tag, " mem_we"}, 64'(mem_we), 64'(st));
            check(mem_be == be_exp, {tag, " R6 mem_be"}, 64'(mem_be), 64'(be_exp));
            if (st) begin
                check(mem_wdata == wexp, {tag, " R7 mem_wdata"}, mem_wdata, wexp);
                for (int b = 0; b < 8; b++)
                    if (be_exp[b]) shadow[ea[6:3]][8*b +: 8] = wexp[8*b +: 8];
            end
        end
        e.cyc = cyc; e.valid = !mis; e.fault = mis; e.tag = tag;
        e.wb  = !mis && !pcr && (mode == 2'd1 || mode == 2'd2);
        e.wbv = e.wb ? sum : 32'h0;
        e.lo = '0; e.hi = '0;
        if (!mis && !st) begin
            word = shadow[ea[6:3]];
            sh   = word >> (8 * lane);
            case (size)
                2'd0: e.lo = {24'h0, sh[7:0]};
                2'd1: e.lo = {16'h0, sh[15:0]};
                2'd2: e.lo = sh[31:0];
                default: begin e.lo = word[31:0]; e.hi = word[63:32]; end
            endcase
        end
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        req_valid = 1'b0;
        e.cyc = cyc; e.valid = 0; e.wb = 0; e.wbv = '0; e.lo = '0; e.hi = '0;
        e.fault = 0; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            ram[i]    = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_1111_1111_1111);
            shadow[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        check(rsp_valid == 0 && wb_en == 0 && align_fault == 0, "R12 reset flags",
              64'({rsp_valid, wb_en, align_fault}), 64'h0);
        check(rsp_load_lo == 0 && rsp_load_hi == 0, "R12 reset load data",
              {rsp_load_hi, rsp_load_lo}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Stores
        issue(1, 2'd0, 2'd2, 0, 32'h100, 0, 13'd8,     32'hCAFE_F00D, 0, "R1 plain word store");
        issue(1, 2'd0, 2'd0, 0, 32'h110, 0, 13'd3,     32'h0000_005A, 0, "R6 byte store lane3");
        issue(1, 2'd3, 2'd1, 0, 32'h120, 0, -13'sd2,   32'h0000_BEEF, 0, "R4 R1 neg-offset half store");
        issue(1, 2'd1, 2'd3, 0, 32'h128, 0, 13'd8,     32'h1111_2222, 32'h3333_4444, "R2 R9 pre dword store");
        issue(1, 2'd2, 2'd2, 0, 32'h138, 0, 13'h10,    32'h7777_8888, 0, "R3 post word store");
        // Loads
        issue(0, 2'd0, 2'd0, 0, 32'h113, 0, 13'd0,     0, 0, "R4 R8 byte load zero offset");
        issue(0, 2'd0, 2'd1, 0, 32'h120, 0, -13'sd2,   0, 0, "R8 half load lane6");
        issue(0, 2'd0, 2'd2, 0, 32'h108, 0, 13'd4,     0, 0, "R8 word load upper lane");
        issue(0, 2'd0, 2'd2, 0, 32'h100, 0, 13'd8,     0, 0, "R8 word load stored");
        issue(0, 2'd2, 2'd3, 0, 32'h130, 0, -13'sd16,  0, 0, "R3 R9 post dword load");
        issue(0, 2'd1, 2'd0, 0, 32'h140, 0, -13'sd7,   0, 0, "R2 pre byte load");
        issue(0, 2'd1, 2'd3, 1, 32'hFFF0, 32'h100, 13'h30, 0, 0, "R5 pc-rel pre dword load");
        issue(1, 2'd2, 2'd0, 1, 32'h0, 32'h105, 13'd1, 32'h0000_00C3, 0, "R5 pc-rel post byte store");
        issue(0, 2'd0, 2'd3, 0, 32'h100, 0, 13'd0,     0, 0, "R11 dword readback");
        idle("R11 idle");
        // Misaligned requests
        issue(0, 2'd0, 2'd1, 0, 32'h101, 0, 13'd0,     0, 0, "R10 odd half load");
        issue(0, 2'd1, 2'd2, 0, 32'h100, 0, 13'd2,     0, 0, "R10 pre word misaligned");
        issue(1, 2'd2, 2'd3, 0, 32'h104, 0, 13'd8,     32'hDEAD_DEAD, 32'hDEAD_DEAD, "R10 post dword store misaligned");
        issue(0, 2'd0, 2'd3, 0, 32'h100, 0, 13'd0,     0, 0, "R10 memory untouched after refused store");
        issue(0, 2'd0, 2'd0, 0, 32'h107, 0, 13'd0,     0, 0, "R8 byte load lane7");
        idle("R11 drain");
        idle("R11 drain2");

        finished = 1;
        summary();
        $finish;
    end

endmodule